// File: doc/BRIEF.md
# Fetch-Stage Branch Target Cache

This block gives the fetch stage an early guess of where to fetch next, before any instruction has been decoded. Every cycle the fetch unit presents its current fetch address. If that address matches a stored branch, the block reports a hit together with the stored target, and fetch uses that target as its next address. A hit therefore stands for a taken prediction. On a miss the block offers the sequential next fetch address, which stands for a not-taken prediction. No direction bits are kept.

Entries are never created at fetch time. The later history-based predictor, or branch resolution, drives a separate update port. It uses that port to install a branch that is now predicted taken, or to remove a branch that is now predicted not taken. Only branches with a fixed target may be installed: unconditional branches and PC-relative conditional branches. Branches through the count or link register are refused, so fetch always treats them as not taken. Because each stored target is fixed, a hit on a taken branch always supplies the right target.

The default geometry is 256 entries arranged as 128 sets of two ways. Addresses are byte addresses of 4-byte words.

Top module: `fetch_target_cache`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) invalidates every entry. From the first cycle after reset, every lookup misses.
- R2: An install (`upd_valid`=1, `upd_taken`=1, fixed-target kind) of pc P with target T becomes visible from the next cycle. A lookup of P then gives `lk_hit`=1, `lk_target`=T with bits 1:0 forced to zero, and `lk_next`=`lk_target`. The lookup is combinational in the cycle the address is presented.
- R3: On a miss, `lk_hit`=0 and `lk_next`=`lk_addr`+`FETCH_BYTES` (default 16).
- R4: `upd_kind` is encoded 0 = unconditional, 1 = PC-relative conditional, 2 = via count register, 3 = via link register. An install with kind 2 or 3 writes nothing, and a later lookup of that pc misses. Kinds 0 and 1 are installed.
- R5: A remove (`upd_valid`=1, `upd_taken`=0) invalidates the entry matching `upd_pc`, and leaves the other way of the set intact. A remove never inserts anything.
- R6: Two branches with the same set index but different tags are held at the same time in the two ways. No set ever matches one lookup in more than one way.
- R7: Each set keeps a most-recently-used way. A lookup hit and an install both mark their way as most recently used. An install of a new tag into a full set evicts the least recently used way.
- R8: Installing a pc that is already present rewrites its target in the same way and does not evict the other way.
- R9: When a lookup and an update address the same set in one cycle, the lookup returns the contents from before the update. The update is seen from the next cycle, and its effect on recency is applied after the lookup's.
- R10: The set index is word-address bits [IDX_W+1:2] (bits 8:2 by default), and the tag is all bits above them. Bits 1:0 are ignored, and addresses that differ only in the tag do not alias.
- R11: An install of a new tag fills an invalid way of the set before it evicts a valid one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Fetch lookup request |
| lk_addr | input | ADDR_W | Current fetch byte address |
| lk_hit | output | 1 | Stored taken branch found |
| lk_target | output | ADDR_W | Stored target on a hit, zero on a miss |
| lk_next | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | Update command present |
| upd_taken | input | 1 | 1 = install as taken, 0 = remove |
| upd_kind | input | 2 | Branch class of the update |
| upd_pc | input | ADDR_W | Branch address being updated |
| upd_target | input | ADDR_W | Branch target to store |

## Verification
Lookup results are combinational, so `lk_hit`, `lk_target` and `lk_next` are due in the same cycle the address is driven. The bench drives inputs at the falling edge and samples one time unit later, before the next rising edge. Updates and reset take hold at the following rising edge, so each update task releases its command after that edge, and the lookup that checks it is made in the next cycle. The same-cycle case is checked twice: once before the shared edge, where the old contents must still show, and once after it.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  typedef enum logic [1:0] {
    BK_UNCOND    = 2'd0,
    BK_RELCOND   = 2'd1,
    BK_VIA_COUNT = 2'd2,
    BK_VIA_LINK  = 2'd3
  } br_kind_e;

  // Only branch classes whose target is fixed may be cached.
  function automatic logic kind_cacheable(input logic [1:0] kind);
    return (kind == BK_UNCOND) || (kind == BK_RELCOND);
  endfunction

endpackage

// File: rtl/ftc_way.sv
module ftc_way #(
  parameter int SETS  = 128,
  parameter int IDX_W = 7,
  parameter int TAG_W = 23,
  parameter int TGT_W = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_match,
  output logic [TGT_W-1:0] rd_tgt,
  input  logic [IDX_W-1:0] up_set,
  input  logic [TAG_W-1:0] up_tag,
  output logic             up_match,
  output logic             up_occupied,
  input  logic             wr_en,
  input  logic [TGT_W-1:0] wr_tgt,
  input  logic             clr_en
);

  logic [SETS-1:0]  vld;
  logic [TAG_W-1:0] tags [SETS];
  logic [TGT_W-1:0] tgts [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[up_set] <= 1'b1;
    end else if (clr_en) begin
      vld[up_set] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tags[up_set] <= up_tag;
      tgts[up_set] <= wr_tgt;
    end
  end

  assign rd_match    = vld[rd_set] && (tags[rd_set] == rd_tag);
  assign rd_tgt      = tgts[rd_set];
  assign up_match    = vld[up_set] && (tags[up_set] == up_tag);
  assign up_occupied = vld[up_set];

endmodule

// File: rtl/ftc_repl.sv
module ftc_repl #(
  parameter int SETS  = 128,
  parameter int IDX_W = 7,
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_touch,
  input  logic [IDX_W-1:0] lk_set,
  input  logic [WAY_W-1:0] lk_way,
  input  logic             up_touch,
  input  logic [IDX_W-1:0] up_set,
  input  logic [WAY_W-1:0] up_way,
  input  logic [WAYS-1:0]  up_occupied,
  output logic [WAY_W-1:0] victim
);

  logic [WAY_W-1:0] mru [SETS];

  function automatic logic [WAY_W-1:0] way_after(input logic [WAY_W-1:0] m);
    return (m == WAY_W'(WAYS - 1)) ? '0 : m + 1'b1;
  endfunction

  // The update is applied after the lookup, so it wins on the same set.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) mru[s] <= '0;
    end else begin
      if (lk_touch) mru[lk_set] <= lk_way;
      if (up_touch) mru[up_set] <= up_way;
    end
  end

  always_comb begin
    victim = way_after(mru[up_set]);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!up_occupied[w]) victim = WAY_W'(w);
    end
  end

endmodule

// File: rtl/fetch_target_cache.sv
module fetch_target_cache #(
  parameter int ADDR_W      = 32,
  parameter int SETS        = 128,
  parameter int WAYS        = 2,
  parameter int FETCH_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_target,
  output logic [ADDR_W-1:0] lk_next,
  input  logic              upd_valid,
  input  logic              upd_taken,
  input  logic [1:0]        upd_kind,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target
);
  import ftc_pkg::*;

  localparam int OFS_W = 2;
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W = ADDR_W - OFS_W - IDX_W;
  localparam int TGT_W = ADDR_W - OFS_W;

  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [WAY_W-1:0] first_way(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (v[w]) r = WAY_W'(w);
    end
    return r;
  endfunction

  logic [IDX_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [WAYS-1:0]  rd_match, up_match, up_occupied;
  logic [TGT_W-1:0] rd_tgt [WAYS];
  logic [WAYS-1:0]  way_hit;
  logic [WAYS-1:0]  wr_en, clr_en;
  logic [WAY_W-1:0] hit_way, victim, ins_way;
  logic             install_req, remove_req;
  logic [TGT_W-1:0] sel_tgt;
  logic             unused_low_bits;

  assign lk_set = set_of(lk_addr);
  assign lk_tag = tag_of(lk_addr);
  assign up_set = set_of(upd_pc);
  assign up_tag = tag_of(upd_pc);
  assign unused_low_bits = ^{upd_target[OFS_W-1:0]};

  assign install_req = upd_valid && upd_taken && kind_cacheable(upd_kind);
  assign remove_req  = upd_valid && !upd_taken;

  assign ins_way = (|up_match) ? first_way(up_match) : victim;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wr_en[w]  = install_req && (ins_way == WAY_W'(w));
    assign clr_en[w] = remove_req && up_match[w];

    ftc_way #(
      .SETS (SETS),
      .IDX_W(IDX_W),
      .TAG_W(TAG_W),
      .TGT_W(TGT_W)
    ) u_way (
      .clk        (clk),
      .rst        (rst),
      .rd_set     (lk_set),
      .rd_tag     (lk_tag),
      .rd_match   (rd_match[w]),
      .rd_tgt     (rd_tgt[w]),
      .up_set     (up_set),
      .up_tag     (up_tag),
      .up_match   (up_match[w]),
      .up_occupied(up_occupied[w]),
      .wr_en      (wr_en[w]),
      .wr_tgt     (upd_target[ADDR_W-1:OFS_W]),
      .clr_en     (clr_en[w])
    );

    assign way_hit[w] = lk_valid && rd_match[w];
  end

  assign hit_way = first_way(way_hit);

  always_comb begin
    sel_tgt = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) sel_tgt = rd_tgt[w];
    end
  end

  ftc_repl #(
    .SETS (SETS),
    .IDX_W(IDX_W),
    .WAYS (WAYS),
    .WAY_W(WAY_W)
  ) u_repl (
    .clk        (clk),
    .rst        (rst),
    .lk_touch   (|way_hit),
    .lk_set     (lk_set),
    .lk_way     (hit_way),
    .up_touch   (install_req),
    .up_set     (up_set),
    .up_way     (ins_way),
    .up_occupied(up_occupied),
    .victim     (victim)
  );

  assign lk_hit    = |way_hit;
  assign lk_target = lk_hit ? {sel_tgt, {OFS_W{1'b0}}} : '0;
  assign lk_next   = lk_hit ? lk_target : lk_addr + ADDR_W'(FETCH_BYTES);

endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic [ADDR_W-1:0] lk_target,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic [1:0]        upd_kind,
  input logic [ADDR_W-1:0] upd_pc,
  input logic [ADDR_W-1:0] upd_target,
  input logic [WAYS-1:0]   way_hit,
  input logic [WAYS-1:0]   wr_en
);

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && lk_valid) |-> !lk_hit);

  assert_install_visible_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(upd_valid && upd_taken && !upd_kind[1]) && !$past(rst) && lk_valid &&
     lk_addr[ADDR_W-1:2] == $past(upd_pc[ADDR_W-1:2]))
    |-> (lk_hit && lk_target == {$past(upd_target[ADDR_W-1:2]), 2'b00}));

  assert_indirect_refused_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_kind[1]) |-> (wr_en == '0));

  assert_remove_clears_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(upd_valid && !upd_taken) && !$past(rst) && lk_valid &&
     lk_addr[ADDR_W-1:2] == $past(upd_pc[ADDR_W-1:2])) |-> !lk_hit);

  assert_single_way_hit_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_hit));

endmodule

bind fetch_target_cache ftc_checker #(
  .ADDR_W(ADDR_W),
  .WAYS  (WAYS)
) u_ftc_checker (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .lk_addr   (lk_addr),
  .lk_hit    (lk_hit),
  .lk_target (lk_target),
  .upd_valid (upd_valid),
  .upd_taken (upd_taken),
  .upd_kind  (upd_kind),
  .upd_pc    (upd_pc),
  .upd_target(upd_target),
  .way_hit   (way_hit),
  .wr_en     (wr_en)
);

// File: tb/fetch_target_cache_test.sv
module fetch_target_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int FB = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          lk_valid;
  logic [AW-1:0] lk_addr;
  logic          lk_hit;
  logic [AW-1:0] lk_target;
  logic [AW-1:0] lk_next;
  logic          upd_valid;
  logic          upd_taken;
  logic [1:0]    upd_kind;
  logic [AW-1:0] upd_pc;
  logic [AW-1:0] upd_target;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fetch_target_cache uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_target(lk_target), .lk_next(lk_next),
    .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_kind(upd_kind),
    .upd_pc(upd_pc), .upd_target(upd_target)
  );

  // Same-set addresses differ by multiples of 0x200 (bits 8:2 equal).
  localparam logic [AW-1:0] A = 32'h0000_1040;
  localparam logic [AW-1:0] B = 32'h0000_1240;
  localparam logic [AW-1:0] P = 32'h0000_2080;
  localparam logic [AW-1:0] Q = 32'h0000_2280;
  localparam logic [AW-1:0] R = 32'h0000_2480;
  localparam logic [AW-1:0] U = 32'h0000_30C0;
  localparam logic [AW-1:0] V = 32'h0000_32C0;
  localparam logic [AW-1:0] W = 32'h0000_34C0;

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic update(input logic taken, input logic [1:0] kind,
                        input logic [AW-1:0] pc, input logic [AW-1:0] tgt);
    @(negedge clk);
    upd_valid = 1'b1; upd_taken = taken; upd_kind = kind; upd_pc = pc; upd_target = tgt;
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
  endtask

  task automatic look(input string req, input logic [AW-1:0] addr,
                      input logic exp_hit, input logic [AW-1:0] exp_tgt);
    logic [AW-1:0] nxt;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = addr;
    #1;
    nxt = exp_hit ? {exp_tgt[AW-1:2], 2'b00} : addr + AW'(FB);
    check(req, {31'd0, lk_hit}, {31'd0, exp_hit});
    check(req, lk_next, nxt);
    @(posedge clk);
    #1;
    lk_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    look("R1", A, 1'b0, '0);
    look("R3", P, 1'b0, '0);
  endtask

  task automatic t_install();
    update(1'b1, 2'd0, A, 32'h0000_8000);
    look("R2", A, 1'b1, 32'h0000_8000);
    look("R10", A | 32'h3, 1'b1, 32'h0000_8000);
    look("R10", B, 1'b0, '0);
    update(1'b1, 2'd1, 32'h0000_5000, 32'h0000_9003);
    look("R2", 32'h0000_5000, 1'b1, 32'h0000_9000);
  endtask

  task automatic t_indirect();
    update(1'b1, 2'd2, 32'h0000_6000, 32'h0000_7000);
    look("R4", 32'h0000_6000, 1'b0, '0);
    update(1'b1, 2'd3, 32'h0000_6100, 32'h0000_7100);
    look("R4", 32'h0000_6100, 1'b0, '0);
  endtask

  task automatic t_remove();
    update(1'b1, 2'd0, B, 32'h0000_8800);
    look("R6", A, 1'b1, 32'h0000_8000);
    look("R6", B, 1'b1, 32'h0000_8800);
    update(1'b0, 2'd0, A, '0);
    look("R5", A, 1'b0, '0);
    look("R5", B, 1'b1, 32'h0000_8800);
    update(1'b0, 2'd1, 32'h0000_6200, 32'h0000_1111);
    look("R5", 32'h0000_6200, 1'b0, '0);
  endtask

  task automatic t_lru();
    update(1'b1, 2'd0, P, 32'h0000_A000);
    update(1'b1, 2'd0, Q, 32'h0000_B000);
    look("R7", P, 1'b1, 32'h0000_A000);
    update(1'b1, 2'd0, R, 32'h0000_C000);
    look("R7", Q, 1'b0, '0);
    look("R7", P, 1'b1, 32'h0000_A000);
    look("R7", R, 1'b1, 32'h0000_C000);
  endtask

  task automatic t_reinstall();
    update(1'b1, 2'd1, P, 32'h0000_D000);
    look("R8", P, 1'b1, 32'h0000_D000);
    look("R8", R, 1'b1, 32'h0000_C000);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = R;
    upd_valid = 1'b1; upd_taken = 1'b0; upd_kind = 2'd0; upd_pc = R; upd_target = '0;
    #1;
    check("R9", {31'd0, lk_hit}, 32'd1);
    check("R9", lk_next, 32'h0000_C000);
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    check("R9", {31'd0, lk_hit}, 32'd0);
    check("R9", lk_next, R + AW'(FB));
    lk_valid = 1'b0;
  endtask

  task automatic t_invalid_first();
    update(1'b1, 2'd0, U, 32'h0000_E000);
    update(1'b1, 2'd0, V, 32'h0000_F000);
    update(1'b0, 2'd0, V, '0);
    update(1'b1, 2'd0, W, 32'h0001_0000);
    look("R11", U, 1'b1, 32'h0000_E000);
    look("R11", W, 1'b1, 32'h0001_0000);
  endtask

  task automatic t_reset_again();
    do_reset();
    look("R1", P, 1'b0, '0);
    look("R1", U, 1'b0, '0);
  endtask

  initial begin
    rst = 1'b1; lk_valid = 1'b0; lk_addr = '0;
    upd_valid = 1'b0; upd_taken = 1'b0; upd_kind = 2'd0; upd_pc = '0; upd_target = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_install();
    t_indirect();
    t_remove();
    t_lru();
    t_reinstall();
    t_same_cycle();
    t_invalid_first();
    t_reset_again();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule